// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns characters written by a processor into an asynchronous serial bit stream. Each character is written through a write-only holding port. It waits either in a single holding slot or, when queueing is switched on, in a 16-deep first-in first-out queue. From there it moves into a shift register that frames it and sends it out. A frame has a low start bit, then 5 to 9 data bits sent least significant first, then an optional even or odd parity bit, then one or two high stop bits. An external generator supplies a baud enable pulse, and every bit lasts 16 of those pulses.

Software watches two flags in an 8-bit line status word. The holding-empty flag means a new character can be written. The transmitter-empty flag means the queue and the shifter are both idle. An interrupt request follows the holding-empty flag while it is enabled, and a write clears it. A break control forces the line low for as long as it is held. Changing the queueing mode discards every character still waiting.

The frame sequencer has six states. IDLE moves to START when a character is available, and that character is popped in the same cycle. START moves to DATA after one bit time. DATA stays in DATA until the last configured bit has been sent. It then moves to PARITY if parity is on, and to STOP1 otherwise. PARITY moves to STOP1. STOP1 moves to STOP2 if two stop bits are chosen, and to IDLE otherwise. STOP2 moves to IDLE.

Top module: `serial_tx_core`

## Requirements
- R1: After synchronous reset, `txd` is 1, `line_status[5]` (holding empty) is 1, `line_status[6]` (transmitter empty) is 1, and all other `line_status` bits are 0.
- R2: A frame starts with one low start bit, then sends the data bits least significant first, then ends with a high stop bit. Every bit lasts 16 `baud_tick` pulses, and the line rests high between frames.
- R3: `cfg_len` codes 0 to 4 select 5 to 9 data bits. Codes 5 to 7 select 9 bits. `wr_data` bits above the selected length are not sent.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. When `cfg_par_odd` is 0, it makes the count of ones over the sent data bits plus parity even. When `cfg_par_odd` is 1, it makes that count odd.
- R5: When `cfg_two_stop` is 1, each frame ends with two high stop bits.
- R6: When `cfg_fifo_en` is 0, only one character can wait behind the shifter. A write while that slot is full is dropped.
- R7: When `cfg_fifo_en` is 1, up to 16 characters can wait behind the shifter. A write while 16 are waiting is dropped.
- R8: `line_status[5]` is 0 in the cycle after an accepted write. It returns to 1 once nothing waits. `irq` equals `irq_en` AND `line_status[5]`.
- R9: `line_status[6]` is 1 only while nothing waits and no frame is being sent.
- R10: While `cfg_break` is 1, `txd` is 0.
- R11: Any change of `cfg_fifo_en` discards every waiting character. `line_status[5]` reads 1 in the next cycle. A frame already in the shifter still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | Baud enable, 16 pulses per bit |
| wr_en | input | 1 | Write strobe for the holding port |
| wr_data | input | 9 | Character to send |
| cfg_fifo_en | input | 1 | 1 enables 16-deep queueing |
| cfg_len | input | 3 | Data length code |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_break | input | 1 | Force the line low |
| irq_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial output |
| line_status | output | 8 | Bit 5 holding empty, bit 6 transmitter empty |
| irq | output | 1 | Transmit interrupt request |

## Verification
The sequencer's pop and a processor write can land in the same cycle. This happens when a write arrives while a frame is ending, or while characters are being written back to back into a queue whose head is being taken. A mode change can also coincide with a shifter that is still busy. The bench provokes the first case with one-per-cycle bursts right behind a loaded shifter, and with random gaps between writes. It provokes the second by toggling the mode while one frame is in flight and two characters wait. A receiver model samples every bit at its middle and compares each frame, and the number of frames, with a queue of expected characters built from the requirements. It also checks the holding-empty, transmitter-empty and interrupt flags at the cycles where they must change.

// File: rtl/stx_pkg.sv
package stx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP1, ST_STOP2
    } tx_state_t;

    localparam int LEN_W = 4;

    // code 0..4 -> 5..9 bits, larger codes -> 9 bits
    function automatic logic [LEN_W-1:0] code_to_len(input logic [2:0] code);
        return (code > 3'd4) ? LEN_W'(9) : LEN_W'(code) + LEN_W'(5);
    endfunction
endpackage

// File: rtl/stx_queue.sv
module stx_queue #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              single,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = single ? (count != '0) : (count == CW'(DEPTH));
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + CW'(1);
            else if (pop_ok && !push_ok) count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/stx_framer.sv
module stx_framer
    import stx_pkg::*;
#(
    parameter int DATA_W        = 9,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    output logic              src_pop,
    output logic              busy,
    output logic              ser_bit
);
    localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

    tx_state_t         state_q, state_d;
    logic [TW-1:0]     tick_q;
    logic [LEN_W-1:0]  idx_q, len_q;
    logic [DATA_W-1:0] sh_q, mask, masked;
    logic              par_q, pen_q, two_q, bit_done;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) mask[i] = (i < int'(cfg_len));
    end
    assign masked   = src_data & mask;
    assign bit_done = baud_tick && (tick_q == TW'(TICKS_PER_BIT - 1));

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (src_valid) state_d = ST_START;
            ST_START:  if (bit_done) state_d = ST_DATA;
            ST_DATA:   if (bit_done && idx_q == len_q - LEN_W'(1))
                           state_d = pen_q ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (bit_done) state_d = ST_STOP1;
            ST_STOP1:  if (bit_done) state_d = two_q ? ST_STOP2 : ST_IDLE;
            ST_STOP2:  if (bit_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tick_q  <= '0;
            idx_q   <= '0;
            len_q   <= LEN_W'(8);
            sh_q    <= '0;
            par_q   <= 1'b0;
            pen_q   <= 1'b0;
            two_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                tick_q <= '0;
                if (src_valid) begin
                    sh_q  <= masked;
                    par_q <= (^masked) ^ cfg_par_odd;
                    len_q <= cfg_len;
                    pen_q <= cfg_par_en;
                    two_q <= cfg_two_stop;
                    idx_q <= '0;
                end
            end else if (baud_tick) begin
                tick_q <= bit_done ? '0 : tick_q + TW'(1);
            end
            if (state_q == ST_DATA && bit_done) begin
                sh_q  <= sh_q >> 1;
                idx_q <= idx_q + LEN_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        src_pop = (state_q == ST_IDLE) && src_valid;
        busy    = (state_q != ST_IDLE);
        unique case (state_q)
            ST_START:  ser_bit = 1'b0;
            ST_DATA:   ser_bit = sh_q[0];
            ST_PARITY: ser_bit = par_q;
            default:   ser_bit = 1'b1;
        endcase
    end
endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
    import stx_pkg::*;
#(
    parameter int DATA_W        = 9,
    parameter int FIFO_DEPTH    = 16,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_fifo_en,
    input  logic [2:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_break,
    input  logic              irq_en,
    output logic              txd,
    output logic [7:0]        line_status,
    output logic              irq
);
    logic              fifo_en_q, flush;
    logic              q_empty, q_full, pop, busy, ser_bit;
    logic [DATA_W-1:0] head;

    always_ff @(posedge clk) begin
        if (rst) fifo_en_q <= 1'b0;
        else     fifo_en_q <= cfg_fifo_en;
    end
    assign flush = (cfg_fifo_en != fifo_en_q);

    stx_queue #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_queue (
        .clk(clk), .rst(rst), .flush(flush), .single(!cfg_fifo_en),
        .push(wr_en), .push_data(wr_data), .pop(pop),
        .head(head), .empty(q_empty), .full(q_full)
    );

    stx_framer #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_framer (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .src_valid(!q_empty), .src_data(head),
        .cfg_len(code_to_len(cfg_len)), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .src_pop(pop), .busy(busy), .ser_bit(ser_bit)
    );

    assign txd         = cfg_break ? 1'b0 : ser_bit;
    assign line_status = {1'b0, q_empty && !busy, q_empty, 5'b0};
    assign irq         = irq_en && q_empty;
endmodule

// File: rtl/stx_checker.sv
module stx_checker (
    input logic       clk,
    input logic       rst,
    input logic       txd,
    input logic       brk,
    input logic       irq,
    input logic       wr_en,
    input logic       flush,
    input logic [7:0] line_status
);
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (txd && line_status[5] && line_status[6]));

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
        (line_status[6] && !brk) |-> txd);

    assert_write_clears_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && line_status[5] && !flush) |=> (!irq && !line_status[5]));

    assert_temt_needs_thre_R9: assert property (@(posedge clk) disable iff (rst)
        line_status[6] |-> line_status[5]);

    assert_break_low_R10: assert property (@(posedge clk) disable iff (rst)
        brk |-> !txd);

    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (rst)
        flush |=> line_status[5]);
endmodule

bind serial_tx_core stx_checker u_chk (
    .clk(clk), .rst(rst), .txd(txd), .brk(cfg_break), .irq(irq),
    .wr_en(wr_en), .flush(flush), .line_status(line_status)
);

// File: tb/serial_tx_core_tb.sv
`timescale 1ns/1ps
module serial_tx_core_tb;
    logic       clk = 0, rst = 1, baud_tick = 0, wr_en = 0;
    logic [8:0] wr_data = 0;
    logic       cfg_fifo_en = 0, cfg_par_en = 0, cfg_par_odd = 0;
    logic       cfg_two_stop = 0, cfg_break = 0, irq_en = 0;
    logic [2:0] cfg_len = 3'd3;
    logic       txd, irq;
    logic [7:0] line_status;

    int checks = 0, errors = 0, frames = 0;
    bit mon_en = 1;
    logic [8:0] exp_q[$];

    always #2.5 clk = ~clk;

    serial_tx_core u_dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .cfg_fifo_en(cfg_fifo_en), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_break(cfg_break), .irq_en(irq_en),
        .txd(txd), .line_status(line_status), .irq(irq)
    );

    // baud tick every other cycle: one bit = 32 clocks
    initial forever begin @(negedge clk); baud_tick = ~baud_tick; end

    function automatic int blen(input logic [2:0] code);
        return (code > 3'd4) ? 9 : int'(code) + 5;
    endfunction

    function automatic logic [8:0] cut(input logic [8:0] d, input logic [2:0] code);
        logic [8:0] m;
        for (int i = 0; i < 9; i++) m[i] = (i < blen(code));
        return d & m;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rx_frame();
        int n = blen(cfg_len);
        logic [8:0] d = 0;
        logic [8:0] e;
        repeat (15) @(negedge clk);
        check(txd == 1'b0, "R2 start bit", int'(txd), 0);
        for (int i = 0; i < n; i++) begin
            repeat (32) @(negedge clk);
            d[i] = txd;
        end
        if (cfg_par_en) begin
            repeat (32) @(negedge clk);
            check(txd == ((^d) ^ cfg_par_odd), "R4 parity bit", int'(txd),
                  int'((^d) ^ cfg_par_odd));
        end
        repeat (32) @(negedge clk);
        check(txd == 1'b1, "R2 stop bit", int'(txd), 1);
        if (cfg_two_stop) begin
            repeat (32) @(negedge clk);
            check(txd == 1'b1, "R5 second stop bit", int'(txd), 1);
        end
        frames++;
        if (exp_q.size() == 0) begin
            check(0, "R6/R7/R11 unexpected frame", int'(d), 0);
        end else begin
            e = exp_q.pop_front();
            check(d == e, "R2/R3 frame data", int'(d), int'(e));
        end
    endtask

    initial forever begin
        @(negedge clk);
        if (mon_en && !rst && txd === 1'b0) rx_frame();
    end

    task automatic put(input logic [8:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (line_status[6] !== 1'b1 && t < 20000) begin @(negedge clk); t++; end
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R9 all expected frames sent", exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [8:0] d;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        check(line_status == 8'h60, "R1 line status", int'(line_status), 'h60);
        check(irq == 1'b0, "R1 irq with enable low", int'(irq), 0);
        irq_en = 1;
        @(negedge clk);
        check(irq == 1'b1, "R8 irq follows empty flag", int'(irq), 1);

        // R8 write clears interrupt, 8N1 frame
        @(negedge clk); wr_en = 1; wr_data = 9'h0A5; exp_q.push_back(9'h0A5);
        @(negedge clk); wr_en = 0;
        check(line_status[5] == 1'b0, "R8 holding flag after write", int'(line_status[5]), 0);
        check(irq == 1'b0, "R8 irq cleared by write", int'(irq), 0);
        @(negedge clk);
        check(line_status[5] == 1'b1, "R8 holding empty after load", int'(line_status[5]), 1);
        check(line_status[6] == 1'b0, "R9 not empty while sending", int'(line_status[6]), 0);
        wait_idle();

        // R6 single slot: shifter + 1 held, third dropped
        put(9'h031); exp_q.push_back(9'h031);
        repeat (4) @(negedge clk);
        put(9'h0C2); exp_q.push_back(9'h0C2);
        put(9'h07E);
        check(line_status[5] == 1'b0, "R6 slot full", int'(line_status[5]), 0);
        wait_idle();

        // R7 queue of 16 behind a busy shifter, 17th dropped
        cfg_fifo_en = 1;
        repeat (3) @(negedge clk);
        put(9'h011); exp_q.push_back(9'h011);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 17; i++) begin
            @(negedge clk); wr_en = 1; wr_data = 9'(8'h40 + i);
            if (i < 16) exp_q.push_back(9'(8'h40 + i));
        end
        @(negedge clk); wr_en = 0;
        check(line_status[5] == 1'b0, "R7 queue holds data", int'(line_status[5]), 0);
        wait_idle();
        check(frames == 20, "R7 frame count", frames, 20);

        // R11 mode change discards waiting characters
        put(9'h05A); exp_q.push_back(9'h05A);
        repeat (4) @(negedge clk);
        put(9'h066); put(9'h077);
        @(negedge clk); cfg_fifo_en = 0;
        @(negedge clk);
        check(line_status[5] == 1'b1, "R11 flush empties queue", int'(line_status[5]), 1);
        check(line_status[6] == 1'b0, "R11 shifter keeps sending", int'(line_status[6]), 0);
        wait_idle();
        cfg_fifo_en = 1;
        repeat (3) @(negedge clk);

        // R10 break
        mon_en = 0;
        @(negedge clk); cfg_break = 1;
        @(negedge clk);
        check(txd == 1'b0, "R10 break low", int'(txd), 0);
        repeat (50) @(negedge clk);
        check(txd == 1'b0, "R10 break held", int'(txd), 0);
        cfg_break = 0;
        @(negedge clk);
        check(txd == 1'b1, "R10 break released", int'(txd), 1);
        mon_en = 1;

        // R3 R4 R5 random formats, mostly back-to-back writes in queue mode
        for (int g = 0; g < 10; g++) begin
            cfg_len      = 3'($urandom_range(0, 7));
            cfg_par_en   = 1'($urandom_range(0, 1));
            cfg_par_odd  = 1'($urandom_range(0, 1));
            cfg_two_stop = 1'($urandom_range(0, 1));
            if (g == 0) begin cfg_len = 3'd0; cfg_par_en = 1; cfg_par_odd = 0; end
            if (g == 1) begin cfg_len = 3'd4; cfg_par_en = 1; cfg_par_odd = 1; end
            if (g == 2) begin cfg_len = 3'd6; cfg_two_stop = 1; end
            for (int k = 0; k < 4; k++) begin
                d = 9'($urandom_range(0, 511));
                exp_q.push_back(cut(d, cfg_len));
                put(d);
                repeat ($urandom_range(0, 3)) @(negedge clk);
            end
            wait_idle();
        end
        check(frames == 61, "R3 total frames", frames, 61);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule